// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block controls a 32-pin parallel I/O port through a small word-addressed register bus. Each pin belongs either to the port logic or to one of two peripheral functions, called A and B. A pin that belongs to the port logic has its direction, output level, open-drain mode and pull-up set by software. A pin handed to a peripheral takes its output value and output enable from that peripheral.

Every configuration field is changed through a pair of write-only addresses. One address sets the bits written as 1 and the other clears them. A third, read-only address returns the stored field. Software can therefore change one pin without a read-modify-write. The pad levels pass through a two-flop synchronizer and can be read back at any time, whatever each pin's owner or direction.

Bus reads are registered. A read strobe at one clock edge loads `bus_rd_data`, and the value holds until the next read strobe. Bits [1:0] of the address are ignored. Word offsets are listed in the requirements as byte addresses.

Top module: `sc_gpio_port`

## Requirements
- R1: Reset state (synchronous, rst_n low): every pin owned by the port (ownership status reads 0xFFFFFFFF). Output enable, output data, open-drain and peripheral-select status all read 0. Pull-ups are enabled, so pull-up status reads 0 and pad_pu is all ones. pad_oe is 0 and bus_rd_data is 0.
- R2: Ownership: writing to 0x00 sets the port-owns-pin bit of each pin whose written bit is 1, and writing to 0x04 clears it. Status is at 0x08. Written 0 bits leave their pins unchanged.
- R3: Peripheral choice: writing to 0x40 selects peripheral B for each pin whose written bit is 1, and writing to 0x3C selects peripheral A for those pins. Status is at 0x44 and reads 1 for B, 0 for A.
- R4: A pin whose ownership bit is 0 drives pad_oe and pad_out from the selected peripheral's oe/out inputs.
- R5: Direction: writing to 0x0C sets output-enable bits and writing to 0x10 clears them. Status is at 0x14. A port-owned pin with open-drain off drives pad_oe from its output-enable bit.
- R6: Output level: writing to 0x18 sets output-data bits and writing to 0x1C clears them. Status is at 0x20. A port-owned pin with open-drain off drives pad_out from its output-data bit.
- R7: Open drain: writing to 0x24 sets and writing to 0x28 clears the per-pin open-drain bit. Status is at 0x2C. A port-owned output pin in this mode with data 1 releases the pad (pad_oe 0). With data 0 it drives the pad low (pad_oe 1, pad_out 0). It never drives high.
- R8: Pull-up: writing to 0x30 enables and writing to 0x34 disables the pull-up of the pins whose written bit is 1. Status at 0x38 reads 1 for a disabled pull-up. pad_pu is 1 exactly where the pull-up is enabled.
- R9: Pin data at 0x48 returns pad_in through a two-flop synchronizer, regardless of owner and direction. A read strobe issued at the clock edge right after pad_in changes still returns the old level. A read strobe issued after two clock edges returns the new level.
- R10: Reads of write-only addresses (0x00, 0x04, 0x0C, 0x10, 0x18, 0x1C, 0x24, 0x28, 0x30, 0x34, 0x3C, 0x40) and of unmapped addresses return 0. bus_rd_data changes only at an edge where bus_rd_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address, bits [1:0] ignored |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data, one bit per pin |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 32 | Registered read data |
| per_a_oe | input | 32 | Peripheral A output enable per pin |
| per_a_out | input | 32 | Peripheral A output value per pin |
| per_b_oe | input | 32 | Peripheral B output enable per pin |
| per_b_out | input | 32 | Peripheral B output value per pin |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_oe | output | 32 | Pad output enable |
| pad_out | output | 32 | Pad output value |
| pad_pu | output | 32 | Pad pull-up enable |

## Verification
A wrong stored bit in any configuration field reaches pad_oe, pad_out or pad_pu right after the clock edge that writes it, because the pin mux is combinational from the field registers. The same fault also shows on the status read one cycle after its strobe. A decode fault that lets a set address touch the wrong field, or lets a 0 bit change a pin, is caught by a status readback after each write. A synchronizer with the wrong depth appears as pin data arriving one read too early or too late.

// File: rtl/sc_gpio_pkg.sv
// Package: shared word indices and field numbering for the set/clear GPIO port.
// Assumes a word-addressed map where the index is the byte address shifted right by 2.
package sc_gpio_pkg;

    localparam int IDX_W = 6;

    // Word indices of the register map (byte address = index * 4)
    localparam logic [IDX_W-1:0] IDX_OWN_SET  = 6'd0;
    localparam logic [IDX_W-1:0] IDX_OWN_CLR  = 6'd1;
    localparam logic [IDX_W-1:0] IDX_OWN_STS  = 6'd2;
    localparam logic [IDX_W-1:0] IDX_OE_SET   = 6'd3;
    localparam logic [IDX_W-1:0] IDX_OE_CLR   = 6'd4;
    localparam logic [IDX_W-1:0] IDX_OE_STS   = 6'd5;
    localparam logic [IDX_W-1:0] IDX_OD_SET   = 6'd6;
    localparam logic [IDX_W-1:0] IDX_OD_CLR   = 6'd7;
    localparam logic [IDX_W-1:0] IDX_OD_STS   = 6'd8;
    localparam logic [IDX_W-1:0] IDX_MD_SET   = 6'd9;
    localparam logic [IDX_W-1:0] IDX_MD_CLR   = 6'd10;
    localparam logic [IDX_W-1:0] IDX_MD_STS   = 6'd11;
    localparam logic [IDX_W-1:0] IDX_PU_EN    = 6'd12;
    localparam logic [IDX_W-1:0] IDX_PU_DIS   = 6'd13;
    localparam logic [IDX_W-1:0] IDX_PU_STS   = 6'd14;
    localparam logic [IDX_W-1:0] IDX_SEL_A    = 6'd15;
    localparam logic [IDX_W-1:0] IDX_SEL_B    = 6'd16;
    localparam logic [IDX_W-1:0] IDX_SEL_STS  = 6'd17;
    localparam logic [IDX_W-1:0] IDX_PIN_DATA = 6'd18;

    // Field numbering: each field occupies three consecutive words
    typedef enum int {
        GRP_OWN   = 0,
        GRP_OE    = 1,
        GRP_OD    = 2,
        GRP_MD    = 3,
        GRP_PUDIS = 4,
        GRP_SELB  = 5
    } grp_e;

    localparam int NGRP = 6;

    // Word index that sets bits of a field (selection field: peripheral B word)
    function automatic logic [IDX_W-1:0] grp_set_idx(input int g);
        if (g == GRP_PUDIS) return IDX_PU_DIS;
        if (g == GRP_SELB)  return IDX_SEL_B;
        return IDX_W'(3 * g);
    endfunction

    // Word index that clears bits of a field
    function automatic logic [IDX_W-1:0] grp_clr_idx(input int g);
        if (g == GRP_PUDIS) return IDX_PU_EN;
        if (g == GRP_SELB)  return IDX_SEL_A;
        return IDX_W'(3 * g + 1);
    endfunction

    // Word index that reads a field back
    function automatic logic [IDX_W-1:0] grp_sts_idx(input int g);
        return IDX_W'(3 * g + 2);
    endfunction

endpackage

// File: rtl/sc_gpio_screg.sv
// Module: one set/clear configuration field.
// Bits written as 1 on the set strobe become 1, bits written as 1 on the clear strobe
// become 0, all others hold. Assumes set and clear never arrive in the same cycle
// (they come from distinct addresses); set wins if they do.
module sc_gpio_screg #(
    parameter int         W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Field storage with bitwise set/clear update
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= RST_VAL;
        else if (set_stb) q <= q | wdata;
        else if (clr_stb) q <= q & ~wdata;
    end

endmodule

// File: rtl/sc_gpio_sync.sv
// Module: multi-stage synchronizer for the pad input levels.
// Assumes each bit is independent; no bus coherency is promised across bits.
module sc_gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop of the asynchronous pad levels
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                // Further resolution stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sc_gpio_pinmux.sv
// Module: per-pin output multiplexer.
// A port-owned pin drives from its own direction/data with optional open-drain; a pin
// given away drives from peripheral A or B. Assumes all inputs are registered upstream.
module sc_gpio_pinmux #(
    parameter int W = 32
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] sel_b,
    input  logic [W-1:0] oe,
    input  logic [W-1:0] od,
    input  logic [W-1:0] md,
    input  logic [W-1:0] a_oe,
    input  logic [W-1:0] a_out,
    input  logic [W-1:0] b_oe,
    input  logic [W-1:0] b_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            logic port_oe;
            logic port_out;

            // Port-side drive: open-drain pins only pull low
            always_comb begin
                if (md[i]) begin
                    port_oe  = oe[i] & ~od[i];
                    port_out = 1'b0;
                end else begin
                    port_oe  = oe[i];
                    port_out = od[i];
                end
            end

            // Ownership selection between port, peripheral A and peripheral B
            always_comb begin
                if (own[i]) begin
                    pin_oe[i]  = port_oe;
                    pin_out[i] = port_out;
                end else if (sel_b[i]) begin
                    pin_oe[i]  = b_oe[i];
                    pin_out[i] = b_out[i];
                end else begin
                    pin_oe[i]  = a_oe[i];
                    pin_out[i] = a_out[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sc_gpio_port.sv
// Module: top of the set/clear GPIO port controller.
// Decodes the register bus into set/clear strobes for six fields, muxes the pads and
// returns registered read data. Assumes one access per cycle and bus_addr[1:0] == 0.
module sc_gpio_port
    import sc_gpio_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr_en,
    input  logic [NPINS-1:0] bus_wr_data,
    input  logic             bus_rd_en,
    output logic [NPINS-1:0] bus_rd_data,
    input  logic [NPINS-1:0] per_a_oe,
    input  logic [NPINS-1:0] per_a_out,
    input  logic [NPINS-1:0] per_b_oe,
    input  logic [NPINS-1:0] per_b_out,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_pu
);

    localparam int WORD_AW = AW - 2;

    logic [IDX_W-1:0] word_idx;
    logic [NPINS-1:0] grp_q [NGRP];
    logic [NPINS-1:0] own_q;
    logic [NPINS-1:0] md_q;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] rd_next;

    // Word index from the byte address
    always_comb begin
        word_idx = '0;
        word_idx[WORD_AW-1:0] = bus_addr[AW-1:2];
    end

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_field
            logic set_stb;
            logic clr_stb;

            // Strobe decode for this field's set and clear words
            always_comb begin
                set_stb = bus_wr_en && (word_idx == grp_set_idx(g));
                clr_stb = bus_wr_en && (word_idx == grp_clr_idx(g));
            end

            sc_gpio_screg #(
                .W       (NPINS),
                .RST_VAL ((g == GRP_OWN) ? {NPINS{1'b1}} : {NPINS{1'b0}})
            ) field_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_stb (set_stb),
                .clr_stb (clr_stb),
                .wdata   (bus_wr_data),
                .q       (grp_q[g])
            );
        end
    endgenerate

    assign own_q = grp_q[GRP_OWN];
    assign md_q  = grp_q[GRP_MD];

    sc_gpio_sync #(
        .W      (NPINS),
        .STAGES (2)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    sc_gpio_pinmux #(
        .W (NPINS)
    ) mux_i (
        .own     (grp_q[GRP_OWN]),
        .sel_b   (grp_q[GRP_SELB]),
        .oe      (grp_q[GRP_OE]),
        .od      (grp_q[GRP_OD]),
        .md      (grp_q[GRP_MD]),
        .a_oe    (per_a_oe),
        .a_out   (per_a_out),
        .b_oe    (per_b_oe),
        .b_out   (per_b_out),
        .pin_oe  (pad_oe),
        .pin_out (pad_out)
    );

    // Pull-up drive is the inverse of the stored disable field
    assign pad_pu = ~grp_q[GRP_PUDIS];

    // Read selection: status words and pin data, zero elsewhere
    always_comb begin
        rd_next = '0;
        for (int k = 0; k < NGRP; k++) begin
            if (word_idx == grp_sts_idx(k)) rd_next = grp_q[k];
        end
        if (word_idx == IDX_PIN_DATA) rd_next = pin_sync;
    end

    // Registered read data, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_rd_data <= '0;
        else if (bus_rd_en) bus_rd_data <= rd_next;
    end

endmodule

// File: rtl/sc_gpio_checker.sv
// Module: assertion checker bound to sc_gpio_port.
// Watches the bus, the pads and two stored fields; assumes the pin and address widths
// match the bound instance.
module sc_gpio_checker
    import sc_gpio_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr_en,
    input  logic [NPINS-1:0] bus_wr_data,
    input  logic             bus_rd_en,
    input  logic [NPINS-1:0] bus_rd_data,
    input  logic [NPINS-1:0] pad_oe,
    input  logic [NPINS-1:0] pad_out,
    input  logic [NPINS-1:0] pad_pu,
    input  logic [NPINS-1:0] own_q,
    input  logic [NPINS-1:0] md_q
);

    logic [IDX_W-1:0] idx;
    logic             wo_addr;
    logic             rst_n_q;

    // Word index and write-only address flag seen by the checker
    always_comb begin
        idx = '0;
        idx[AW-3:0] = bus_addr[AW-1:2];
        wo_addr = (idx == IDX_OWN_SET) || (idx == IDX_OWN_CLR) ||
                  (idx == IDX_SEL_A)   || (idx == IDX_SEL_B)   ||
                  (idx == IDX_PU_EN)   || (idx == IDX_PU_DIS);
    end

    // Remember the reset level of the previous edge
    always_ff @(posedge clk) rst_n_q <= rst_n;

    p_reset_pads_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n_q == 1'b0) |-> (pad_oe == '0) && (pad_pu == '1) && (bus_rd_data == '0));

    p_od_low_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & own_q & md_q) == '0));

    p_pu_dis_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && idx == IDX_PU_DIS) |=> ((pad_pu & $past(bus_wr_data)) == '0));

    p_pu_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && idx == IDX_PU_EN) |=>
            ((pad_pu & $past(bus_wr_data)) == $past(bus_wr_data)));

    p_wo_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && wo_addr) |=> (bus_rd_data == '0));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_en && rst_n_q) |=> $stable(bus_rd_data));

endmodule

bind sc_gpio_port sc_gpio_checker #(.NPINS(NPINS), .AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_en   (bus_rd_en),
    .bus_rd_data (bus_rd_data),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pu      (pad_pu),
    .own_q       (own_q),
    .md_q        (md_q)
);

// File: tb/sc_gpio_port_tb.sv
// Directed bench for sc_gpio_port: one task per scenario, each checking its results.
module sc_gpio_port_tb_top;

    localparam int NP = 32;
    localparam int AW = 8;
    localparam time TCLK = 4ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] bus_addr;
    logic          bus_wr_en;
    logic [NP-1:0] bus_wr_data;
    logic          bus_rd_en;
    logic [NP-1:0] bus_rd_data;
    logic [NP-1:0] per_a_oe, per_a_out, per_b_oe, per_b_out;
    logic [NP-1:0] pad_in, pad_oe, pad_out, pad_pu;

    int n_checks = 0;
    int n_fail   = 0;

    always #(TCLK/2) clk = ~clk;

    sc_gpio_port #(.NPINS(NP), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .per_a_oe(per_a_oe), .per_a_out(per_a_out), .per_b_oe(per_b_oe),
        .per_b_out(per_b_out), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input string what,
                       input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [NP-1:0] d);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [NP-1:0] d);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rd_data;
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a,
                            input logic [NP-1:0] exp);
        logic [NP-1:0] v;
        bus_read(a, v);
        chk(req, $sformatf("read 0x%02h", a), v, exp);
    endtask

    task automatic t_reset;
        chk("R1", "pad_oe", pad_oe, '0);
        chk("R1", "pad_pu", pad_pu, '1);
        chk("R1", "rd_data", bus_rd_data, '0);
        read_chk("R1", 8'h08, 32'hFFFF_FFFF);
        read_chk("R1", 8'h14, '0);
        read_chk("R1", 8'h20, '0);
        read_chk("R1", 8'h2C, '0);
        read_chk("R1", 8'h38, '0);
        read_chk("R1", 8'h44, '0);
    endtask

    task automatic t_owner;
        bus_write(8'h04, 32'h0000_00FF);
        read_chk("R2", 8'h08, 32'hFFFF_FF00);
        bus_write(8'h00, 32'h0000_000F);
        read_chk("R2", 8'h08, 32'hFFFF_FF0F);
        bus_write(8'h00, 32'h0000_0000);
        read_chk("R2", 8'h08, 32'hFFFF_FF0F);
    endtask

    task automatic t_periph;
        logic [NP-1:0] m;
        per_a_oe = '1; per_a_out = 32'hAAAA_AAAA;
        per_b_oe = 32'h0000_0010; per_b_out = 32'h5555_5555;
        bus_write(8'h40, 32'h0000_0030);
        read_chk("R3", 8'h44, 32'h0000_0030);
        m = 32'h0000_00F0;
        // pins 4,5 from B, pins 6,7 from A
        chk("R4", "pad_oe peripheral pins", pad_oe & m, 32'h0000_00D0);
        chk("R4", "pad_out peripheral pins", pad_out & m,
            (per_b_out & 32'h30) | (per_a_out & 32'hC0));
        bus_write(8'h3C, 32'h0000_0010);
        read_chk("R3", 8'h44, 32'h0000_0020);
        chk("R4", "pin4 back on A", pad_out & 32'h10, per_a_out & 32'h10);
        bus_write(8'h00, '1);
        read_chk("R2", 8'h08, '1);
    endtask

    task automatic t_drive;
        bus_write(8'h0C, 32'h0000_FFFF);
        read_chk("R5", 8'h14, 32'h0000_FFFF);
        chk("R5", "pad_oe", pad_oe, 32'h0000_FFFF);
        bus_write(8'h18, 32'h00FF_00FF);
        read_chk("R6", 8'h20, 32'h00FF_00FF);
        chk("R6", "pad_out", pad_out, 32'h00FF_00FF);
        bus_write(8'h1C, 32'h0000_000F);
        read_chk("R6", 8'h20, 32'h00FF_00F0);
        bus_write(8'h10, 32'h0000_FF00);
        read_chk("R5", 8'h14, 32'h0000_00FF);
        chk("R5", "pad_oe after clear", pad_oe, 32'h0000_00FF);
    endtask

    task automatic t_open_drain;
        bus_write(8'h24, 32'h0000_00FF);
        read_chk("R7", 8'h2C, 32'h0000_00FF);
        chk("R7", "pad_oe open drain", pad_oe & 32'hFF, 32'h0000_000F);
        chk("R7", "pad_out open drain", pad_out & 32'hFF, 32'h0000_0000);
        bus_write(8'h28, 32'h0000_00FF);
        read_chk("R7", 8'h2C, '0);
        chk("R7", "pad_oe push-pull", pad_oe & 32'hFF, 32'h0000_00FF);
        chk("R7", "pad_out push-pull", pad_out & 32'hFF, 32'h0000_00F0);
    endtask

    task automatic t_pullup;
        bus_write(8'h34, 32'h0F0F_0F0F);
        read_chk("R8", 8'h38, 32'h0F0F_0F0F);
        chk("R8", "pad_pu", pad_pu, 32'hF0F0_F0F0);
        bus_write(8'h30, 32'h0000_000F);
        read_chk("R8", 8'h38, 32'h0F0F_0F00);
        chk("R8", "pad_pu re-enabled", pad_pu, 32'hF0F0_F0FF);
    endtask

    task automatic t_pin_data;
        pad_in = 32'h1234_5678;
        @(negedge clk); @(negedge clk);
        read_chk("R9", 8'h48, 32'h1234_5678);
        pad_in = 32'hCAFE_0001;
        read_chk("R9", 8'h48, 32'h1234_5678);
        @(negedge clk);
        read_chk("R9", 8'h48, 32'hCAFE_0001);
    endtask

    task automatic t_readonly;
        logic [NP-1:0] held;
        read_chk("R10", 8'h00, '0);
        read_chk("R10", 8'h0C, '0);
        read_chk("R10", 8'h30, '0);
        read_chk("R10", 8'h3C, '0);
        read_chk("R10", 8'h4C, '0);
        read_chk("R10", 8'hFC, '0);
        read_chk("R10", 8'h08, '1);
        held = bus_rd_data;
        bus_addr = 8'h00;
        @(negedge clk); @(negedge clk);
        chk("R10", "rd_data holds without strobe", bus_rd_data, held);
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr_en = 1'b0; bus_wr_data = '0;
        bus_rd_en = 1'b0; per_a_oe = '0; per_a_out = '0; per_b_oe = '0;
        per_b_out = '0; pad_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_owner();
        t_periph();
        t_drive();
        t_open_drain();
        t_pullup();
        t_pin_data();
        t_readonly();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(TCLK * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule